// File: doc/BRIEF.md
# Page access rights checker

This block takes the rights gathered from a finished page-table walk and decides whether a single access may proceed. The walk supplies the user, writable and no-execute rights of the final translation and the protection key of the last entry. The requester supplies the access kind, its privilege level, and the protection mode controls. The block returns three things: the read/write/execute permission set for the page, an allow/deny verdict for this access, and the page-fault error code to report when the access is denied.

The decision logic is combinational. All results are captured in one output register stage, so a request presented with `req_valid` in one cycle produces its answer on the following cycle with `res_valid` high. Walking the tables and setting accessed or dirty flags are left to the surrounding translation logic. That logic also reports a reserved-bit violation it found during the walk through `rsvd_hit`.

Top module: `prc_access_checker`

## Requirements
- R1: `acc_kind` encodes the access as 0 = read, 1 = write, 2 = instruction fetch; code 3 is handled exactly like a read. `res_perm` bit 0 is read, bit 1 is write, bit 2 is execute, and the access is allowed only when the permission bit selected by the access kind is set.
- R2: A user-privilege access (`priv_user` = 1) to a page whose user right is clear is a protection fault: it is denied, `res_perm` is all zero, and the error code has bits 0 and 2 set.
- R3: With a supervisor access in the supervisor-access-prevention context (`smap_ctx` = 1), a page with the user right set grants neither read nor write. `smap_ctx` has no effect on user-privilege accesses.
- R4: Write is granted when the page is writable, or when the access is supervisor and `md_wp` is clear.
- R5: Execute is granted when the no-execute right is clear and either the access is user privilege or `md_smep` is clear or the page is a supervisor page.
- R6: A page with the user right set takes its key rights from `ukey_reg`, but only when `md_pke` is set. A supervisor page takes them from `skey_reg`, but only when `md_pks` is set. For key k, the access-disable flag is register bit 2k and the write-disable flag is bit 2k+1. When the selected register is disabled or all zero, keys have no effect.
- R7: An access-disable flag removes read and write. A write-disable flag removes write only for user-privilege accesses or when `md_wp` is set. Keys never remove execute, so a key fault never arises on a fetch.
- R8: When the access is allowed, `res_err` is zero. When it is denied, `res_err` carries the following bits:
  - bit 0 is always set;
  - bit 1 is set for a write;
  - bit 2 is set for a user-privilege access;
  - bit 3 is set for a reserved-bit fault;
  - bit 4 is set for a fetch when `md_nxe` or `md_smep` is set;
  - bit 5 is set when the key rights alone deny the access.
- R9: `rsvd_hit` takes precedence over every other check. The access is denied with bits 0 and 3 set, bit 5 clear, and `res_perm` all zero.
- R10: Results appear on the cycle after `req_valid`, with `res_valid` high for exactly that cycle. Without `req_valid`, the result outputs hold their last value. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| pg_user | input | 1 | Accumulated user right of the translation |
| pg_write | input | 1 | Accumulated writable right |
| pg_nx | input | 1 | Accumulated no-execute right (1 = not executable) |
| pg_key | input | KEY_W | Protection key of the final entry |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| priv_user | input | 1 | Access made at user privilege |
| smap_ctx | input | 1 | Supervisor context that refuses data access to user pages |
| md_wp | input | 1 | Supervisor writes honour read-only pages |
| md_nxe | input | 1 | No-execute feature enabled |
| md_smep | input | 1 | Supervisor fetch from user pages blocked |
| md_pke | input | 1 | User-page protection keys enabled |
| md_pks | input | 1 | Supervisor-page protection keys enabled |
| ukey_reg | input | 2*2**KEY_W | Key rights register for user pages |
| skey_reg | input | 2*2**KEY_W | Key rights register for supervisor pages |
| rsvd_hit | input | 1 | Reserved-bit violation found by the walk |
| res_valid | output | 1 | Result valid |
| res_perm | output | 3 | Permission set: bit 0 read, bit 1 write, bit 2 execute |
| res_allow | output | 1 | Access allowed |
| res_err | output | 6 | Page-fault error code |

## Verification
The hardest case to reach from the ports is a key fault that depends on three controls at once. It takes a write-disable flag placed at exactly the key's bit pair, in the register selected by the page's user right. It also takes the privilege and write-protect combination that makes that flag count. A table entry with a single flag bit at the right position covers each variant: user write, supervisor write with and without `md_wp`, a disabled key enable, and a fetch under all-ones key rights. A directed sweep then walks an access-disable flag across every key position. At each position it checks that only the matching key is refused and that the neighbouring key is still allowed.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    localparam int PERM_W = 3;
    localparam int PRM_RD = 0;
    localparam int PRM_WR = 1;
    localparam int PRM_EX = 2;

    localparam int ERR_W       = 6;
    localparam int ERR_PROT    = 0;
    localparam int ERR_WRITE   = 1;
    localparam int ERR_USER    = 2;
    localparam int ERR_RSVD    = 3;
    localparam int ERR_FETCH   = 4;
    localparam int ERR_PKEY    = 5;

endpackage

// File: rtl/prc_base_rights.sv
module prc_base_rights
    import prc_pkg::*;
(
    input  logic              pg_user,
    input  logic              pg_write,
    input  logic              pg_nx,
    input  logic              priv_user,
    input  logic              smap_ctx,
    input  logic              md_wp,
    input  logic              md_smep,
    output logic [PERM_W-1:0] base_perm,
    output logic              priv_fault
);
    logic smap_block;
    logic smep_block;

    always_comb begin
        priv_fault = priv_user && !pg_user;
        smap_block = !priv_user && smap_ctx && pg_user;
        smep_block = !priv_user && md_smep && pg_user;

        base_perm[PRM_RD] = !smap_block;
        base_perm[PRM_WR] = !smap_block && (pg_write || (!priv_user && !md_wp));
        base_perm[PRM_EX] = !pg_nx && !smep_block;
    end
endmodule

// File: rtl/prc_key_gate.sv
module prc_key_gate
    import prc_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int NKEYS = 2 ** KEY_W,
    localparam int PKR_W = 2 * NKEYS
) (
    input  logic              pg_user,
    input  logic              priv_user,
    input  logic              md_wp,
    input  logic              md_pke,
    input  logic              md_pks,
    input  logic [KEY_W-1:0]  pg_key,
    input  logic [PKR_W-1:0]  ukey_reg,
    input  logic [PKR_W-1:0]  skey_reg,
    output logic [PERM_W-1:0] key_mask,
    output logic              key_active
);
    logic [PKR_W-1:0] sel_reg;
    logic [NKEYS-1:0] ad_vec;
    logic [NKEYS-1:0] wd_vec;
    logic             ad_flag;
    logic             wd_flag;

    always_comb begin
        if (pg_user) begin
            sel_reg = md_pke ? ukey_reg : '0;
        end else begin
            sel_reg = md_pks ? skey_reg : '0;
        end
    end

    for (genvar g = 0; g < NKEYS; g++) begin : g_pair
        assign ad_vec[g] = sel_reg[2*g];
        assign wd_vec[g] = sel_reg[2*g+1];
    end

    always_comb begin
        key_active = |sel_reg;
        ad_flag    = ad_vec[pg_key];
        wd_flag    = wd_vec[pg_key] && (priv_user || md_wp);

        key_mask[PRM_RD] = !ad_flag;
        key_mask[PRM_WR] = !ad_flag && !wd_flag;
        key_mask[PRM_EX] = 1'b1;
    end
endmodule

// File: rtl/prc_fault_encode.sv
module prc_fault_encode
    import prc_pkg::*;
(
    input  logic [1:0]        acc_kind,
    input  logic              priv_user,
    input  logic              md_nxe,
    input  logic              md_smep,
    input  logic              rsvd_hit,
    input  logic              priv_fault,
    input  logic [PERM_W-1:0] base_perm,
    input  logic [PERM_W-1:0] key_mask,
    input  logic              key_active,
    output logic [PERM_W-1:0] eff_perm,
    output logic              allow,
    output logic [ERR_W-1:0]  err_code
);
    acc_kind_e         kind;
    logic [1:0]        idx;
    logic              blocked;
    logic              key_deny;
    logic [PERM_W-1:0] gate;

    always_comb begin
        kind = acc_kind_e'(acc_kind);
        unique case (kind)
            ACC_LOAD:  idx = 2'd0;
            ACC_STORE: idx = 2'd1;
            ACC_FETCH: idx = 2'd2;
            ACC_ALT:   idx = 2'd0;
        endcase

        blocked  = rsvd_hit || priv_fault;
        gate     = key_active ? key_mask : {PERM_W{1'b1}};
        eff_perm = blocked ? '0 : (base_perm & gate);
        key_deny = !blocked && key_active && !key_mask[idx];
        allow    = !blocked && eff_perm[idx];

        err_code = '0;
        if (!allow) begin
            err_code[ERR_PROT]  = 1'b1;
            err_code[ERR_WRITE] = (kind == ACC_STORE);
            err_code[ERR_USER]  = priv_user;
            err_code[ERR_RSVD]  = rsvd_hit;
            err_code[ERR_FETCH] = (kind == ACC_FETCH) && (md_nxe || md_smep);
            err_code[ERR_PKEY]  = key_deny;
        end
    end
endmodule

// File: rtl/prc_access_checker.sv
module prc_access_checker
    import prc_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int PKR_W = 2 * (2 ** KEY_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              pg_user,
    input  logic              pg_write,
    input  logic              pg_nx,
    input  logic [KEY_W-1:0]  pg_key,
    input  logic [1:0]        acc_kind,
    input  logic              priv_user,
    input  logic              smap_ctx,
    input  logic              md_wp,
    input  logic              md_nxe,
    input  logic              md_smep,
    input  logic              md_pke,
    input  logic              md_pks,
    input  logic [PKR_W-1:0]  ukey_reg,
    input  logic [PKR_W-1:0]  skey_reg,
    input  logic              rsvd_hit,
    output logic              res_valid,
    output logic [PERM_W-1:0] res_perm,
    output logic              res_allow,
    output logic [ERR_W-1:0]  res_err
);
    logic [PERM_W-1:0] base_perm;
    logic              priv_fault;
    logic [PERM_W-1:0] key_mask;
    logic              key_active;
    logic [PERM_W-1:0] eff_perm;
    logic              allow_c;
    logic [ERR_W-1:0]  err_c;

    prc_base_rights u_base (
        .pg_user    (pg_user),
        .pg_write   (pg_write),
        .pg_nx      (pg_nx),
        .priv_user  (priv_user),
        .smap_ctx   (smap_ctx),
        .md_wp      (md_wp),
        .md_smep    (md_smep),
        .base_perm  (base_perm),
        .priv_fault (priv_fault)
    );

    prc_key_gate #(.KEY_W(KEY_W)) u_key (
        .pg_user    (pg_user),
        .priv_user  (priv_user),
        .md_wp      (md_wp),
        .md_pke     (md_pke),
        .md_pks     (md_pks),
        .pg_key     (pg_key),
        .ukey_reg   (ukey_reg),
        .skey_reg   (skey_reg),
        .key_mask   (key_mask),
        .key_active (key_active)
    );

    prc_fault_encode u_enc (
        .acc_kind   (acc_kind),
        .priv_user  (priv_user),
        .md_nxe     (md_nxe),
        .md_smep    (md_smep),
        .rsvd_hit   (rsvd_hit),
        .priv_fault (priv_fault),
        .base_perm  (base_perm),
        .key_mask   (key_mask),
        .key_active (key_active),
        .eff_perm   (eff_perm),
        .allow      (allow_c),
        .err_code   (err_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_perm  <= '0;
            res_allow <= 1'b0;
            res_err   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_perm  <= eff_perm;
                res_allow <= allow_c;
                res_err   <= err_c;
            end
        end
    end
endmodule

// File: rtl/prc_access_check_sva.sv
module prc_access_check_sva #(
    parameter int KEY_W = 4,
    localparam int PKR_W = 2 * (2 ** KEY_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             pg_user,
    input logic             pg_write,
    input logic             pg_nx,
    input logic [KEY_W-1:0] pg_key,
    input logic [1:0]       acc_kind,
    input logic             priv_user,
    input logic             smap_ctx,
    input logic             md_wp,
    input logic             md_nxe,
    input logic             md_smep,
    input logic             md_pke,
    input logic             md_pks,
    input logic [PKR_W-1:0] ukey_reg,
    input logic [PKR_W-1:0] skey_reg,
    input logic             rsvd_hit,
    input logic             res_valid,
    input logic [2:0]       res_perm,
    input logic             res_allow,
    input logic [5:0]       res_err
);
    assert_store_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_kind == 2'd1 |=> (!res_allow || res_perm[1]));

    assert_user_on_kernel_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && priv_user && !pg_user |=> !res_allow && res_err[2] && res_err[0] && res_perm == 3'b000);

    assert_smap_blocks_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !priv_user && smap_ctx && pg_user |=> res_perm[1:0] == 2'b00);

    assert_fetch_no_key_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_kind == 2'd2 |=> !res_err[5]);

    assert_deny_sets_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_allow |-> res_err[0]);

    assert_allow_clean_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_allow |-> res_err == 6'd0);

    assert_rsvd_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsvd_hit |=> !res_allow && res_err[3] && !res_err[5] && res_perm == 3'b000);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && $stable(res_perm) && $stable(res_allow) && $stable(res_err));
endmodule

bind prc_access_checker prc_access_check_sva #(.KEY_W(KEY_W)) u_sva (.*);

// File: tb/tb_prc_access_checker.sv
`timescale 1ns/1ps
module tb_prc_access_checker;

    typedef struct packed {
        logic        usr;
        logic        rw;
        logic        nx;
        logic [3:0]  key;
        logic [1:0]  acc;
        logic        puser;
        logic        smap;
        logic        wp;
        logic        nxe;
        logic        smep;
        logic        pke;
        logic        pks;
        logic [31:0] ureg;
        logic [31:0] sreg;
        logic        rsvd;
        logic [2:0]  perm;
        logic        allow;
        logic [5:0]  err;
    } vec_t;

    localparam int NV = 19;
    // usr rw nx key acc puser smap wp nxe smep pke pks ureg sreg rsvd | perm allow err
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,4'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b111,1'b1,6'h00}, // R1 kernel read
        '{1'b1,1'b0,1'b0,4'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b101,1'b0,6'h07}, // R4 user store RO
        '{1'b0,1'b0,1'b0,4'd0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b111,1'b1,6'h00}, // R4 kernel store RO, wp off
        '{1'b0,1'b0,1'b0,4'd0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b101,1'b0,6'h03}, // R4 kernel store RO, wp on
        '{1'b0,1'b1,1'b0,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b000,1'b0,6'h05}, // R2
        '{1'b1,1'b1,1'b0,4'd0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b100,1'b0,6'h01}, // R3
        '{1'b1,1'b1,1'b0,4'd0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0,3'b011,1'b0,6'h11}, // R5 smep
        '{1'b1,1'b1,1'b1,4'd0,2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b011,1'b0,6'h15}, // R5 nx user
        '{1'b0,1'b1,1'b1,4'd0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b011,1'b0,6'h01}, // R8 no fetch bit
        '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'h40,32'h0,1'b0,3'b100,1'b0,6'h25}, // R7 AD
        '{1'b1,1'b1,1'b0,4'd3,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'h80,32'h0,1'b0,3'b101,1'b0,6'h27}, // R7 WD user
        '{1'b0,1'b1,1'b0,4'd5,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,32'h800,1'b0,3'b111,1'b1,6'h00}, // R7 WD kernel wp off
        '{1'b0,1'b1,1'b0,4'd5,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,32'h0,32'h800,1'b0,3'b101,1'b0,6'h23}, // R7 WD kernel wp on
        '{1'b1,1'b1,1'b0,4'd3,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h40,32'h0,1'b0,3'b111,1'b1,6'h00}, // R6 pke off
        '{1'b1,1'b1,1'b0,4'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'hffffffff,32'h0,1'b0,3'b100,1'b1,6'h00}, // R7 fetch keys
        '{1'b0,1'b1,1'b0,4'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b1,3'b000,1'b0,6'h09}, // R9
        '{1'b0,1'b1,1'b0,4'd0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0,3'b111,1'b1,6'h00}, // R1 code 3
        '{1'b1,1'b1,1'b0,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,32'h1,1'b0,3'b111,1'b1,6'h00}, // R6 user page ignores sreg
        '{1'b1,1'b1,1'b0,4'd0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'h0,32'h0,1'b0,3'b111,1'b1,6'h00}  // R6 zero reg bypass
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        pg_user = 1'b0, pg_write = 1'b0, pg_nx = 1'b0;
    logic [3:0]  pg_key = '0;
    logic [1:0]  acc_kind = '0;
    logic        priv_user = 1'b0, smap_ctx = 1'b0, md_wp = 1'b0, md_nxe = 1'b0;
    logic        md_smep = 1'b0, md_pke = 1'b0, md_pks = 1'b0, rsvd_hit = 1'b0;
    logic [31:0] ukey_reg = '0, skey_reg = '0;
    logic        res_valid;
    logic [2:0]  res_perm;
    logic        res_allow;
    logic [5:0]  res_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prc_access_checker #(.KEY_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .pg_user(pg_user), .pg_write(pg_write), .pg_nx(pg_nx), .pg_key(pg_key),
        .acc_kind(acc_kind), .priv_user(priv_user), .smap_ctx(smap_ctx),
        .md_wp(md_wp), .md_nxe(md_nxe), .md_smep(md_smep), .md_pke(md_pke),
        .md_pks(md_pks), .ukey_reg(ukey_reg), .skey_reg(skey_reg),
        .rsvd_hit(rsvd_hit), .res_valid(res_valid), .res_perm(res_perm),
        .res_allow(res_allow), .res_err(res_err)
    );

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: valid/perm/allow/err actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        pg_user = v.usr; pg_write = v.rw; pg_nx = v.nx; pg_key = v.key;
        acc_kind = v.acc; priv_user = v.puser; smap_ctx = v.smap; md_wp = v.wp;
        md_nxe = v.nxe; md_smep = v.smep; md_pke = v.pke; md_pks = v.pks;
        ukey_reg = v.ureg; skey_reg = v.sreg; rsvd_hit = v.rsvd; req_valid = vld;
    endtask

    task automatic apply(input string tag, input vec_t v);
        @(negedge clk);
        drive(v, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {res_valid, res_perm, res_allow, res_err}, {1'b1, v.perm, v.allow, v.err});
    endtask

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset", {res_valid, res_perm, res_allow, res_err}, 11'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply($sformatf("vector %0d", i), VEC[i]);
        end

        // R10: idle cycle holds last result, valid low
        v = VEC[4];
        @(negedge clk);
        drive(v, 1'b0);
        @(negedge clk);
        check("R10 hold", {res_valid, res_perm, res_allow, res_err},
              {1'b0, VEC[NV-1].perm, VEC[NV-1].allow, VEC[NV-1].err});

        // R6/R7: access-disable flag swept over every key position
        for (int k = 0; k < 16; k++) begin
            v = VEC[0];
            v.usr = 1'b1; v.puser = 1'b1; v.pke = 1'b1;
            v.ureg = 32'h1 << (2 * k);
            v.key = 4'(k);
            v.perm = 3'b100; v.allow = 1'b0; v.err = 6'h25;
            apply($sformatf("R6 key %0d hit", k), v);
            v.key = 4'((k + 1) % 16);
            v.perm = 3'b111; v.allow = 1'b1; v.err = 6'h00;
            apply($sformatf("R7 key %0d neighbour", k), v);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule